// File: doc/BRIEF.md
# Multi-channel ADC threshold monitor

This block watches a stream of tagged ADC conversion results and compares each one with a low and a high limit. Each of eight channels has its own limits. Each channel owns an eight-byte register slot. The slot holds an input-select byte, the two 16-bit limits, an interval byte, a control byte and an enable byte. A result carries a channel tag and a 16-bit code. The block evaluates it only if the block is globally enabled and the tagged channel has measurement enabled. A crossing on a side whose interrupt enable is set sets a sticky per-channel status bit.

Low-side and high-side status are kept as two separate bitmask registers. Software clears a bit by writing 1 to it. A single level interrupt is raised while any status bit is set. A byte-wide register port gives access to the slots, the status masks, the global enable and a conversion-request strobe. The strobe is passed on to the converter as a one-cycle pulse.

Top module: `thr_mon`

## Requirements
- R1: After reset every register byte, both status masks, `irq_o` and `conv_req_o` are 0.
- R2: Channel n (0..7) has its slot at address 0x60+8n. The bytes at offsets 0..7 are: input select, low limit LSB, low limit MSB, high limit LSB, high limit MSB, interval, control, enable. All eight bytes read back what was written. Each limit is little-endian: the LSB sits at the lower address.
- R3: A result on channel n with a code strictly below the low limit sets bit n of the low status mask at 0x0a. This happens only when bit 7 (measurement enable) and bit 0 (low interrupt enable) of the channel's enable byte are both set. The bit is readable in the cycle after the result.
- R4: A result with a code strictly above the high limit sets bit n of the high status mask at 0x0b. This happens only when bit 7 and bit 1 (high interrupt enable) of the enable byte are set.
- R5: A code equal to a limit sets no status bit.
- R6: A result is ignored in either of two cases: measurement enable of its channel is clear, or the global enable (bit 7 at 0x46) is clear.
- R7: A crossing on a side whose interrupt enable bit is clear sets no status bit.
- R8: Status bits stay set until 1 is written to that bit of its mask. Writing 0 has no effect. A new crossing in the same cycle as a clear leaves the bit set.
- R9: `irq_o` is high exactly while any bit of either status mask is set. It changes in the same cycle as the status registers.
- R10: Writing a byte with bit 7 set to 0x47 gives a one-cycle `conv_req_o` pulse in the following cycle. Reads of 0x47 return 0.
- R11: Addresses outside the slots, 0x0a, 0x0b, 0x46 and 0x47 read 0, and writes to them change nothing. 0x46 reads back only bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i (combinational) |
| res_valid_i | input | 1 | Conversion result valid |
| res_chan_i | input | 3 | Channel tag of the result |
| res_code_i | input | 16 | Conversion code |
| conv_req_o | output | 1 | One-cycle conversion request pulse |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest case to reach is a single cycle that both clears a status bit and sets it again through a new crossing. The write and the result must land on the same edge. The bench reaches it by driving a clear of the bit together with a result below the low limit in one call. It also reaches it in a long random phase where register writes and results are issued in the same cycle against randomly programmed limits. The reference model then decides every set, clear and interrupt level independently of the design.

// File: rtl/thr_mon_pkg.sv
package thr_mon_pkg;
  localparam int unsigned ADDR_W     = 8;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned CODE_W     = 16;
  localparam int unsigned SLOT_BYTES = 8;

  localparam logic [ADDR_W-1:0] A_STAT_LO   = 8'h0a;
  localparam logic [ADDR_W-1:0] A_STAT_HI   = 8'h0b;
  localparam logic [ADDR_W-1:0] A_GLOBAL    = 8'h46;
  localparam logic [ADDR_W-1:0] A_CONV      = 8'h47;
  localparam logic [ADDR_W-1:0] A_SLOT_BASE = 8'h60;

  typedef enum logic [2:0] {
    B_INSEL = 3'd0, B_LO_L = 3'd1, B_LO_H = 3'd2, B_HI_L = 3'd3,
    B_HI_H  = 3'd4, B_IVAL = 3'd5, B_CTRL = 3'd6, B_ENA  = 3'd7
  } slot_byte_e;

  localparam int unsigned EN_MEAS  = 7;
  localparam int unsigned EN_HI_IE = 1;
  localparam int unsigned EN_LO_IE = 0;
  localparam int unsigned GO_BIT   = 7;
endpackage

// File: rtl/thr_mon_regs.sv
module thr_mon_regs
  import thr_mon_pkg::*;
#(
  parameter int unsigned N_CH = 8,
  localparam int unsigned CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic [DATA_W-1:0]            rdata_o,
  output logic [N_CH-1:0][CODE_W-1:0]  thr_lo_o,
  output logic [N_CH-1:0][CODE_W-1:0]  thr_hi_o,
  output logic [N_CH-1:0]              meas_en_o,
  output logic [N_CH-1:0]              lo_ie_o,
  output logic [N_CH-1:0]              hi_ie_o,
  output logic                         glob_en_o,
  output logic                         conv_req_o
);
  localparam int unsigned SLOT_END = int'(A_SLOT_BASE) + N_CH * SLOT_BYTES;

  logic [ADDR_W-1:0]          slot_off;
  logic [CH_W-1:0]            slot_ch;
  logic [2:0]                 slot_b;
  logic                       in_slots;
  logic [N_CH-1:0][DATA_W-1:0] rd_ch;
  logic                       glob_q, conv_q;

  assign slot_off = addr_i - A_SLOT_BASE;
  assign slot_ch  = slot_off[CH_W+2:3];
  assign slot_b   = slot_off[2:0];
  assign in_slots = (int'(addr_i) >= int'(A_SLOT_BASE)) && (int'(addr_i) < SLOT_END);

  for (genvar c = 0; c < N_CH; c++) begin : g_slot
    logic [DATA_W-1:0] byte_q [SLOT_BYTES];
    logic              sel;
    assign sel = wr_i && in_slots && (slot_ch == CH_W'(c));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int b = 0; b < SLOT_BYTES; b++) byte_q[b] <= '0;
      end else if (sel) begin
        byte_q[slot_b] <= wdata_i;
      end
    end

    assign thr_lo_o[c]  = {byte_q[B_LO_H], byte_q[B_LO_L]};
    assign thr_hi_o[c]  = {byte_q[B_HI_H], byte_q[B_HI_L]};
    assign meas_en_o[c] = byte_q[B_ENA][EN_MEAS];
    assign lo_ie_o[c]   = byte_q[B_ENA][EN_LO_IE];
    assign hi_ie_o[c]   = byte_q[B_ENA][EN_HI_IE];
    assign rd_ch[c]     = byte_q[slot_b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glob_q <= 1'b0;
      conv_q <= 1'b0;
    end else begin
      if (wr_i && addr_i == A_GLOBAL) glob_q <= wdata_i[GO_BIT];
      conv_q <= wr_i && (addr_i == A_CONV) && wdata_i[GO_BIT];
    end
  end

  assign glob_en_o  = glob_q;
  assign conv_req_o = conv_q;

  always_comb begin
    rdata_o = '0;
    if (in_slots)                rdata_o = rd_ch[slot_ch];
    else if (addr_i == A_GLOBAL) rdata_o = {glob_q, 7'b0};
  end

  AST_CONV_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |-> $past(wr_i && addr_i == A_CONV && wdata_i[GO_BIT])); // R10
  AST_GLOBAL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_i && addr_i == A_GLOBAL) |-> $stable(glob_en_o)); // R11
endmodule

// File: rtl/thr_mon_cmp.sv
module thr_mon_cmp
  import thr_mon_pkg::*;
#(
  parameter int unsigned N_CH = 8,
  localparam int unsigned CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         res_valid_i,
  input  logic [CH_W-1:0]              res_chan_i,
  input  logic [CODE_W-1:0]            res_code_i,
  input  logic                         glob_en_i,
  input  logic [N_CH-1:0][CODE_W-1:0]  thr_lo_i,
  input  logic [N_CH-1:0][CODE_W-1:0]  thr_hi_i,
  input  logic [N_CH-1:0]              meas_en_i,
  input  logic [N_CH-1:0]              lo_ie_i,
  input  logic [N_CH-1:0]              hi_ie_i,
  output logic [N_CH-1:0]              lo_set_o,
  output logic [N_CH-1:0]              hi_set_o
);
  for (genvar c = 0; c < N_CH; c++) begin : g_cmp
    logic hit;
    assign hit         = res_valid_i && glob_en_i && meas_en_i[c] && (res_chan_i == CH_W'(c));
    assign lo_set_o[c] = hit && lo_ie_i[c] && (res_code_i < thr_lo_i[c]);
    assign hi_set_o[c] = hit && hi_ie_i[c] && (res_code_i > thr_hi_i[c]);
  end

  AST_SET_ONE_CHANNEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lo_set_o | hi_set_o)); // R3
  AST_IGNORE_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glob_en_i |-> (lo_set_o == '0 && hi_set_o == '0)); // R6
endmodule

// File: rtl/thr_mon_status.sv
module thr_mon_status #(
  parameter int unsigned N_CH = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] lo_set_i,
  input  logic [N_CH-1:0] hi_set_i,
  input  logic [N_CH-1:0] lo_clr_i,
  input  logic [N_CH-1:0] hi_clr_i,
  output logic [N_CH-1:0] lo_q_o,
  output logic [N_CH-1:0] hi_q_o,
  output logic            irq_o
);
  logic [N_CH-1:0] lo_q, hi_q;

  // a set in the same cycle as a clear wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= (lo_q & ~lo_clr_i) | lo_set_i;
      hi_q <= (hi_q & ~hi_clr_i) | hi_set_i;
    end
  end

  assign lo_q_o = lo_q;
  assign hi_q_o = hi_q;
  assign irq_o  = |{lo_q, hi_q};

  AST_LO_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((lo_q & $past(lo_q & ~lo_clr_i)) == $past(lo_q & ~lo_clr_i))); // R8
  AST_HI_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((hi_q & $past(hi_q & ~hi_clr_i)) == $past(hi_q & ~hi_clr_i))); // R8
  AST_LO_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((lo_q & ~$past(lo_q)) & ~$past(lo_set_i)) == '0); // R3
  AST_HI_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((hi_q & ~$past(hi_q)) & ~$past(hi_set_i)) == '0); // R4
endmodule

// File: rtl/thr_mon.sv
module thr_mon
  import thr_mon_pkg::*;
#(
  parameter int unsigned N_CH = 8,
  localparam int unsigned CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              res_valid_i,
  input  logic [CH_W-1:0]   res_chan_i,
  input  logic [CODE_W-1:0] res_code_i,
  output logic              conv_req_o,
  output logic              irq_o
);
  logic [N_CH-1:0][CODE_W-1:0] thr_lo, thr_hi;
  logic [N_CH-1:0] meas_en, lo_ie, hi_ie, lo_set, hi_set, lo_clr, hi_clr, lo_q, hi_q;
  logic            glob_en;
  logic [DATA_W-1:0] regs_rdata;

  thr_mon_regs #(.N_CH(N_CH)) u_regs (
    .clk_i, .rst_ni, .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(regs_rdata), .thr_lo_o(thr_lo), .thr_hi_o(thr_hi), .meas_en_o(meas_en),
    .lo_ie_o(lo_ie), .hi_ie_o(hi_ie), .glob_en_o(glob_en), .conv_req_o(conv_req_o)
  );

  thr_mon_cmp #(.N_CH(N_CH)) u_cmp (
    .clk_i, .rst_ni, .res_valid_i, .res_chan_i, .res_code_i, .glob_en_i(glob_en),
    .thr_lo_i(thr_lo), .thr_hi_i(thr_hi), .meas_en_i(meas_en), .lo_ie_i(lo_ie),
    .hi_ie_i(hi_ie), .lo_set_o(lo_set), .hi_set_o(hi_set)
  );

  assign lo_clr = (reg_wr_i && reg_addr_i == A_STAT_LO) ? reg_wdata_i[N_CH-1:0] : '0;
  assign hi_clr = (reg_wr_i && reg_addr_i == A_STAT_HI) ? reg_wdata_i[N_CH-1:0] : '0;

  thr_mon_status #(.N_CH(N_CH)) u_status (
    .clk_i, .rst_ni, .lo_set_i(lo_set), .hi_set_i(hi_set), .lo_clr_i(lo_clr),
    .hi_clr_i(hi_clr), .lo_q_o(lo_q), .hi_q_o(hi_q), .irq_o(irq_o)
  );

  always_comb begin
    unique case (reg_addr_i)
      A_STAT_LO: reg_rdata_o = DATA_W'(lo_q);
      A_STAT_HI: reg_rdata_o = DATA_W'(hi_q);
      default:   reg_rdata_o = regs_rdata;
    endcase
  end

  AST_IRQ_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|{lo_set, hi_set})); // R9
endmodule

// File: tb/sim_thr_mon.sv
module sim_thr_mon;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [7:0]  reg_addr_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic        res_valid_i = 1'b0;
  logic [2:0]  res_chan_i = '0;
  logic [15:0] res_code_i = '0;
  logic        conv_req_o, irq_o;

  always #2 clk = ~clk;

  thr_mon u0 (.clk_i(clk), .rst_ni, .reg_wr_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
              .res_valid_i, .res_chan_i, .res_code_i, .conv_req_o, .irq_o);

  int   checks = 0, errors = 0;
  bit   done = 0;
  logic [7:0] mem [256];
  bit         glob = 0, exp_conv = 0;
  logic [7:0] lo_s = '0, hi_s = '0;
  logic [7:0] last_addr = '0;
  string      last_req = "R1";

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] model_rd(input logic [7:0] a);
    if (a == 8'h0a) return lo_s;
    if (a == 8'h0b) return hi_s;
    if (a == 8'h46) return {glob, 7'b0};
    if (a >= 8'h60 && a < 8'ha0) return mem[a];
    return 8'h00;
  endfunction

  task automatic cyc(input bit wr, input logic [7:0] a, input logic [7:0] d,
                     input bit v, input logic [2:0] ch, input logic [15:0] code, input string req);
    logic [7:0] lset = '0, hset = '0, en;
    logic [15:0] tlo, thi;
    logic [7:0] base;
    chk(last_req, "rdata", reg_rdata_o, model_rd(last_addr));
    chk(last_req, "irq", irq_o, |(lo_s | hi_s));
    chk(last_req, "conv_req", conv_req_o, exp_conv);
    reg_wr_i = wr; reg_addr_i = a; reg_wdata_i = d;
    res_valid_i = v; res_chan_i = ch; res_code_i = code;
    base = 8'h60 + {2'b0, ch, 3'b0};
    en  = mem[base + 8'd7];
    tlo = {mem[base + 8'd2], mem[base + 8'd1]};
    thi = {mem[base + 8'd4], mem[base + 8'd3]};
    if (v && glob && en[7]) begin
      if (en[0] && code < tlo) lset[ch] = 1'b1;
      if (en[1] && code > thi) hset[ch] = 1'b1;
    end
    lo_s = (lo_s & ~((wr && a == 8'h0a) ? d : 8'h00)) | lset;
    hi_s = (hi_s & ~((wr && a == 8'h0b) ? d : 8'h00)) | hset;
    if (wr && a >= 8'h60 && a < 8'ha0) mem[a] = d;
    if (wr && a == 8'h46) glob = d[7];
    exp_conv = wr && a == 8'h47 && d[7];
    last_addr = a; last_req = req;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input string req);
    cyc(1, a, d, 0, 3'd0, 16'h0, req);
  endtask
  task automatic rd(input logic [7:0] a, input string req);
    cyc(0, a, 8'h00, 0, 3'd0, 16'h0, req);
  endtask
  task automatic res(input logic [2:0] ch, input logic [15:0] code, input logic [7:0] a, input string req);
    cyc(0, a, 8'h00, 1, ch, code, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(8'h0a, "R1"); chk("R1", "stat_lo", reg_rdata_o, 8'h00); chk("R1", "irq", irq_o, 1'b0);
    rd(8'h77, "R1"); chk("R1", "ena", reg_rdata_o, 8'h00);
    chk("R1", "conv_req", conv_req_o, 1'b0);
    // R2 program channel 2 slot: low 0x1000, high 0x3000
    wr(8'h70, 8'h5a, "R2"); wr(8'h71, 8'h00, "R2"); wr(8'h72, 8'h10, "R2");
    wr(8'h73, 8'h00, "R2"); wr(8'h74, 8'h30, "R2"); wr(8'h75, 8'h02, "R2");
    wr(8'h76, 8'h3f, "R2"); wr(8'h77, 8'h83, "R2");
    rd(8'h72, "R2"); chk("R2", "lo_msb", reg_rdata_o, 8'h10);
    rd(8'h70, "R2"); chk("R2", "insel", reg_rdata_o, 8'h5a);
    // R6 global enable still clear
    res(3'd2, 16'h0001, 8'h0a, "R6"); chk("R6", "stat_lo", reg_rdata_o, 8'h00);
    // R11 global readback and unmapped
    wr(8'h46, 8'hff, "R11"); rd(8'h46, "R11"); chk("R11", "global", reg_rdata_o, 8'h80);
    wr(8'h20, 8'hff, "R11"); rd(8'h20, "R11"); chk("R11", "unmapped", reg_rdata_o, 8'h00);
    // R10 conversion request
    wr(8'h47, 8'h80, "R10"); chk("R10", "conv pulse", conv_req_o, 1'b1);
    rd(8'h47, "R10"); chk("R10", "conv low/read", {conv_req_o, reg_rdata_o}, 9'h000);
    // R5 equal codes
    res(3'd2, 16'h1000, 8'h0a, "R5"); res(3'd2, 16'h3000, 8'h0b, "R5");
    chk("R5", "stat_hi", reg_rdata_o, 8'h00); chk("R5", "irq", irq_o, 1'b0);
    // R3, R9
    res(3'd2, 16'h0fff, 8'h0a, "R3"); chk("R3", "stat_lo", reg_rdata_o, 8'h04);
    chk("R9", "irq", irq_o, 1'b1);
    // R4
    res(3'd2, 16'h3001, 8'h0b, "R4"); chk("R4", "stat_hi", reg_rdata_o, 8'h04);
    // R8 write 0, clear, set wins
    wr(8'h0a, 8'h00, "R8"); chk("R8", "stat_lo", reg_rdata_o, 8'h04);
    wr(8'h0a, 8'h04, "R8"); chk("R8", "stat_lo clr", reg_rdata_o, 8'h00);
    wr(8'h0b, 8'h04, "R9"); chk("R9", "irq cleared", irq_o, 1'b0);
    cyc(1, 8'h0a, 8'h04, 1, 3'd2, 16'h0000, "R8"); chk("R8", "set wins", reg_rdata_o, 8'h04);
    wr(8'h0a, 8'hff, "R8");
    // R7 channel 5 measure only, no side enables
    wr(8'h89, 8'h00, "R7"); wr(8'h8a, 8'h01, "R7"); wr(8'h8f, 8'h80, "R7");
    res(3'd5, 16'h0000, 8'h0a, "R7"); chk("R7", "stat_lo", reg_rdata_o, 8'h00);
    // R6 measure clear, low enable set
    wr(8'h8f, 8'h01, "R6");
    res(3'd5, 16'h0000, 8'h0a, "R6"); chk("R6", "meas off", reg_rdata_o, 8'h00);
    // random phase against the model
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      int sel = $urandom_range(0, 9);
      case (sel)
        0, 1, 2, 3: a = 8'h60 + 8'($urandom_range(0, 63));
        4: a = 8'h0a;
        5: a = 8'h0b;
        6: a = 8'h46;
        7: a = 8'h47;
        default: a = 8'($urandom);
      endcase
      cyc(($urandom_range(0, 2) == 0), a, 8'($urandom | ((sel == 6) ? 32'h80 : 0)),
          ($urandom_range(0, 1) == 1), 3'($urandom), 16'($urandom), "R3R4R8");
    end
    rd(8'h00, "R9");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule